// File: doc/BRIEF.md
# Value-Compare Byte Write-Enable Generator

This block sits at the device end of a write path. It accepts a 256-bit write packet, organised as sixteen 16-bit words. It turns that packet into thirty-two byte write enables. There are no per-byte strobe lines. Instead, every byte of the packet is compared against one shared 8-bit reserved value. A byte whose value matches the reserved value is suppressed. Every other byte is written. The sender must pick a reserved value that does not occur among the bytes it wants written. Thirty-two bytes can use at most thirty-two of the 256 possible values, so a free value always exists.

A command input chooses between two kinds of write. In a compare-gated write, the per-byte comparison decides each enable. In an unconditional write, every byte is enabled whatever the reserved value is. Both kinds of write take the same number of cycles.

The enables and the data are captured together in one register stage on a valid strobe. That stage then drives a single 256-bit storage row. The row updates only the bytes whose enables are set, so suppressed bytes keep their old contents.

Top module: `vcmp_byte_we_top`

## Requirements
- R1: Byte k (k = 0..31) is `in_data[8k+7:8k]`, and its enable is bit k of `wr_en`. Word w therefore supplies bit 2w (bits 7:0 of the word) and bit 2w+1 (bits 15:8 of the word).
- R2: When `in_masked` = 1 (compare-gated write), enable bit k is 1 exactly when byte k differs from `in_mask`. The same `in_mask` value applies to all 32 bytes.
- R3: In a compare-gated write, a byte equal to `in_mask` gets enable 0, and the matching byte of `row_data` keeps its previous value.
- R4: When `in_masked` = 0 (unconditional write), all 32 enables are 1, whatever the value of `in_mask`.
- R5: Enables and data presented with `in_valid` high appear on `wr_en`, and `wr_valid` is 1, one clock edge later. Back-to-back valid cycles give back-to-back beats with the same timing for both commands.
- R6: A cycle with `in_valid` low leaves `wr_valid` = 0 and `wr_en` = 0 at the next edge, and leaves `row_data` unchanged, whatever the data and mask inputs are.
- R7: One edge after a beat with `wr_valid` = 1, each enabled byte of `row_data` takes that beat's data byte. All other bytes hold their value.
- R8: Synchronous active-high reset `rst` clears `wr_valid`, `wr_en` and the whole of `row_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write beat present this cycle |
| in_masked | input | 1 | 1 = compare-gated write, 0 = unconditional write |
| in_mask | input | 8 | Shared reserved byte value |
| in_data | input | 256 | Write packet, 16 words of 16 bits |
| wr_valid | output | 1 | Registered beat valid |
| wr_en | output | 32 | Registered per-byte write enables |
| row_data | output | 256 | Contents of the storage row |

## Verification
The enables and `wr_valid` are due one clock edge after the cycle that holds the stimulus. The storage row is due one edge after that, two edges after the stimulus. Inputs are driven on the falling edge. After the next rising edge, the bench checks `wr_en` and `wr_valid` on the following falling edge. It checks `row_data` one full cycle later against a reference row that it keeps itself. In the back-to-back case, the enables of the second beat and the row after the first beat are checked on the same falling edge, which tests that the two pipeline steps stay aligned.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    localparam int WORDS          = 16;
    localparam int WORD_W         = 16;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int NBYTES         = WORDS * BYTES_PER_WORD;
    localparam int DATA_W         = WORDS * WORD_W;

    typedef enum logic {
        WR_PLAIN  = 1'b0,
        WR_MASKED = 1'b1
    } wr_cmd_e;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic              vld;
        logic [NBYTES-1:0] en;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    function automatic byte_t byte_at(input logic [DATA_W-1:0] d, input int idx);
        return d[idx*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/vcmp_byte_cmp.sv
module vcmp_byte_cmp
    import vcmp_pkg::*;
#(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  wr_cmd_e         cmd,
    input  logic [BW-1:0]   mask,
    input  logic [NB*BW-1:0] data,
    output logic [NB-1:0]   en
);

    logic force_all;
    assign force_all = (cmd == WR_PLAIN);

    for (genvar k = 0; k < NB; k++) begin : g_lane
        logic [BW-1:0] lane;
        logic          differs;
        assign lane    = data[k*BW +: BW];
        assign differs = (lane != mask);
        assign en[k]   = force_all | differs;
    end

endmodule

// File: rtl/vcmp_wr_stage.sv
module vcmp_wr_stage
    import vcmp_pkg::*;
#(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [NB-1:0]    in_en,
    input  logic [NB*BW-1:0] in_data,
    output logic             out_vld,
    output logic [NB-1:0]    out_en,
    output logic [NB*BW-1:0] out_data
);

    typedef struct packed {
        logic             vld;
        logic [NB-1:0]    en;
        logic [NB*BW-1:0] data;
    } beat_t;

    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.vld <= in_vld;
            beat_q.en  <= in_vld ? in_en : '0;
            if (in_vld) begin
                beat_q.data <= in_data;
            end
        end
    end

    assign out_vld  = beat_q.vld;
    assign out_en   = beat_q.en;
    assign out_data = beat_q.data;

    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && out_en == '0)); // R6

    AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_vld && out_en == $past(in_en) && out_data == $past(in_data))); // R5

endmodule

// File: rtl/vcmp_row_store.sv
module vcmp_row_store
    import vcmp_pkg::*;
#(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_vld,
    input  logic [NB-1:0]    wr_en,
    input  logic [NB*BW-1:0] wr_data,
    output logic [NB*BW-1:0] row
);

    for (genvar k = 0; k < NB; k++) begin : g_cell
        logic [BW-1:0] cell_q;
        logic          hit;

        assign hit = wr_vld & wr_en[k];

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (hit) begin
                cell_q <= wr_data[k*BW +: BW];
            end
        end

        assign row[k*BW +: BW] = cell_q;

        AST_HELD_BYTE: assert property (@(posedge clk) disable iff (rst)
            !(wr_vld && wr_en[k]) |=> $stable(row[k*BW +: BW])); // R3

        AST_WRITTEN_BYTE: assert property (@(posedge clk) disable iff (rst)
            (wr_vld && wr_en[k]) |=> row[k*BW +: BW] == $past(wr_data[k*BW +: BW])); // R7
    end

endmodule

// File: rtl/vcmp_byte_we_top.sv
module vcmp_byte_we_top
    import vcmp_pkg::*;
#(
    parameter int N_WORDS = WORDS,
    parameter int W_WIDTH = WORD_W,
    parameter int B_WIDTH = BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_masked,
    input  logic [B_WIDTH-1:0]            in_mask,
    input  logic [N_WORDS*W_WIDTH-1:0]    in_data,
    output logic                          wr_valid,
    output logic [N_WORDS*W_WIDTH/B_WIDTH-1:0] wr_en,
    output logic [N_WORDS*W_WIDTH-1:0]    row_data
);

    localparam int LANES = N_WORDS * W_WIDTH / B_WIDTH;
    localparam int DW    = N_WORDS * W_WIDTH;

    wr_cmd_e          cmd;
    logic [LANES-1:0] cmp_en;
    logic [DW-1:0]    stg_data;

    assign cmd = wr_cmd_e'(in_masked);

    vcmp_byte_cmp #(.NB(LANES), .BW(B_WIDTH)) u_cmp (
        .cmd  (cmd),
        .mask (in_mask),
        .data (in_data),
        .en   (cmp_en)
    );

    vcmp_wr_stage #(.NB(LANES), .BW(B_WIDTH)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_valid),
        .in_en    (cmp_en),
        .in_data  (in_data),
        .out_vld  (wr_valid),
        .out_en   (wr_en),
        .out_data (stg_data)
    );

    vcmp_row_store #(.NB(LANES), .BW(B_WIDTH)) u_row (
        .clk     (clk),
        .rst     (rst),
        .wr_vld  (wr_valid),
        .wr_en   (wr_en),
        .wr_data (stg_data),
        .row     (row_data)
    );

    AST_PLAIN_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_masked) |=> (&wr_en)); // R4

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        AST_MATCH_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_masked && in_data[k*B_WIDTH +: B_WIDTH] == in_mask)
            |=> !wr_en[k]); // R3

        AST_MISMATCH_ENABLED: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_masked && in_data[k*B_WIDTH +: B_WIDTH] != in_mask)
            |=> wr_en[k]); // R2
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!wr_valid && wr_en == '0 && row_data == '0)); // R8

endmodule

// File: tb/tb_vcmp_byte_we_top.sv
module tb_vcmp_byte_we_top;

    localparam int NB = 32;
    localparam int DW = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_masked;
    logic [7:0]    in_mask;
    logic [DW-1:0] in_data;
    logic          wr_valid;
    logic [NB-1:0] wr_en;
    logic [DW-1:0] row_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model_row;

    always #4 clk = ~clk;

    vcmp_byte_we_top dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_masked (in_masked),
        .in_mask   (in_mask),
        .in_data   (in_data),
        .wr_valid  (wr_valid),
        .wr_en     (wr_en),
        .row_data  (row_data)
    );

    typedef struct packed {
        logic          masked;
        logic [7:0]    mask;
        logic [DW-1:0] data;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 8'h5A, {16{16'hA55A}}},
        '{1'b1, 8'h00, {32{8'h00}}},
        '{1'b0, 8'h11, {32{8'h11}}},
        '{1'b1, 8'hFF, {8{32'h01FF_FF02}}},
        '{1'b1, 8'h3C, {{28{8'h77}}, {4{8'h3C}}}},
        '{1'b0, 8'h00, {16{16'h00FF}}}
    };

    function automatic logic [NB-1:0] ref_en(input logic m, input logic [7:0] mk,
                                             input logic [DW-1:0] d);
        logic [NB-1:0] r;
        for (int k = 0; k < NB; k++) begin
            r[k] = !m || (d[k*8 +: 8] != mk);
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] ref_row(input logic [DW-1:0] old,
                                              input logic [NB-1:0] en,
                                              input logic [DW-1:0] d);
        logic [DW-1:0] r;
        r = old;
        for (int k = 0; k < NB; k++) begin
            if (en[k]) r[k*8 +: 8] = d[k*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic m, input logic [7:0] mk,
                         input logic [DW-1:0] d);
        in_valid  = v;
        in_masked = m;
        in_mask   = mk;
        in_data   = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One beat: drive, check enables one edge later (R5), check row one edge after that.
    task automatic run_beat(input string tag, input logic m, input logic [7:0] mk,
                            input logic [DW-1:0] d);
        logic [NB-1:0] e;
        e = ref_en(m, mk, d);
        @(negedge clk);
        drive(1'b1, m, mk, d);
        @(negedge clk);
        chk({tag, " R5 wr_valid"}, DW'(wr_valid), DW'(1'b1));
        chk({tag, m ? " R2 wr_en" : " R4 wr_en"}, DW'(wr_en), DW'(e));
        drive(1'b0, 1'b0, 8'h00, '0);
        model_row = ref_row(model_row, e, d);
        @(negedge clk);
        chk({tag, " R3/R7 row"}, row_data, model_row);
        chk({tag, " R6 wr_en after idle"}, DW'(wr_en), '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d1, d2;
        logic [NB-1:0] e1, e2;
        model_row = '0;
        rst = 1'b1;
        drive(1'b0, 1'b0, 8'h00, '0);
        repeat (3) @(negedge clk);
        chk("R8 reset wr_valid", DW'(wr_valid), '0);
        chk("R8 reset wr_en", DW'(wr_en), '0);
        chk("R8 reset row", row_data, '0);
        rst = 1'b0;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            run_beat($sformatf("vec%0d", i), VECS[i].masked, VECS[i].mask, VECS[i].data);
        end

        // R1: single differing byte at lane 5 (bits 47:40) gives enable bit 5 only
        d1 = {32{8'hEE}};
        d1[47:40] = 8'h12;
        @(negedge clk);
        drive(1'b1, 1'b1, 8'hEE, d1);
        @(negedge clk);
        chk("R1 lane position", DW'(wr_en), DW'(32'h0000_0020));
        drive(1'b0, 1'b0, 8'h00, '0);
        model_row = ref_row(model_row, 32'h0000_0020, d1);
        @(negedge clk);
        chk("R1 row byte 5", DW'(row_data[47:40]), DW'(8'h12));
        chk("R1 row full", row_data, model_row);

        // R6: idle cycles with busy data and plain command must not touch the row
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h99, {8{32'hDEAD_BEEF}});
        @(negedge clk);
        chk("R6 idle wr_valid", DW'(wr_valid), '0);
        chk("R6 idle wr_en", DW'(wr_en), '0);
        @(negedge clk);
        chk("R6 idle row", row_data, model_row);
        drive(1'b0, 1'b0, 8'h00, '0);

        // R5: back-to-back beats, one masked then one plain
        d1 = {16{16'h1234}};
        d2 = {{16{8'hAB}}, {16{8'hCD}}};
        e1 = ref_en(1'b1, 8'h34, d1);
        e2 = ref_en(1'b0, 8'hAB, d2);
        @(negedge clk);
        drive(1'b1, 1'b1, 8'h34, d1);
        @(negedge clk);
        chk("R5 b2b first wr_en", DW'(wr_en), DW'(e1));
        drive(1'b1, 1'b0, 8'hAB, d2);
        model_row = ref_row(model_row, e1, d1);
        @(negedge clk);
        chk("R5 b2b second wr_en", DW'(wr_en), DW'(e2));
        chk("R5 b2b second wr_valid", DW'(wr_valid), DW'(1'b1));
        chk("R7 b2b row after first", row_data, model_row);
        drive(1'b0, 1'b0, 8'h00, '0);
        model_row = ref_row(model_row, e2, d2);
        @(negedge clk);
        chk("R7 b2b row after second", row_data, model_row);

        // R3: fully suppressed masked write leaves row intact
        run_beat("R3 all-match", 1'b1, 8'hAB, {32{8'hAB}});

        // R8: reset in the middle of a beat
        @(negedge clk);
        drive(1'b1, 1'b0, 8'h00, {32{8'h5C}});
        rst = 1'b1;
        @(negedge clk);
        chk("R8 mid reset wr_valid", DW'(wr_valid), '0);
        chk("R8 mid reset row", row_data, '0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 8'h00, '0);
        model_row = '0;
        @(negedge clk);
        chk("R8 after reset row", row_data, model_row);

        finish_run();
    end

endmodule